// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block collects message-signalled interrupts and turns them into one level-sensitive interrupt line for a processor. Each incoming message is a single-cycle event that names a bank and a 5-bit vector. Because such a message cannot be withdrawn once sent, the block records it in a sticky status bit instead of passing it on as a pulse. Each bank holds 32 vectors. The number of banks is a parameter. Every status bit that is pending, enabled and unmasked feeds one shared, registered, active-high output `irq`.

Software uses a plain register port. Each bank has three 32-bit registers, selected by `reg_addr[1:0]`:

| `reg_addr[1:0]` | Register | Write behaviour |
|---|---|---|
| 0 | status | write-one-to-clear |
| 1 | enable | plain write |
| 2 | mask | plain write |
| 3 | none | reads return zero |

The upper address bits select the bank. Enable and mask are independent controls:

- An enabled vector records incoming messages.
- A masked vector may hold a set status bit but is kept off the output.
- A disabled vector records nothing.

The message input is a valid/ready stream. `msg_ready` is held high at all times, so the block applies no back-pressure. Every cycle in which `msg_valid` is high delivers exactly one message, and the sender never has to hold a message.

Top module: `msi_agg`

## Requirements
- R1: After reset `irq` is 0, and every status, enable and mask register reads 0.
- R2: A message whose vector is enabled sets status bit `msg_vec` of bank `msg_bank` on the clock edge where `msg_valid` is high. The register at address {bank, 2'd0} reads back that bit.
- R3: A message whose vector is not enabled leaves that status bit unchanged.
- R4: `irq` equals the OR of (status AND enable AND NOT mask) over all banks, taken from the register state before the previous clock edge. It stays high while any such bit remains set and falls once none does.
- R5: A message for an enabled but masked vector sets its status bit, and that bit does not raise `irq`.
- R6: Writing to {bank, 2'd0} clears each status bit where the write data is 1 and leaves bits where the data is 0. Writes to {bank, 2'd1} and {bank, 2'd2} replace the enable and mask words.
- R7: If a message and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: Clearing the mask of a vector whose status bit is already set raises `irq` one edge after the mask register changes.
- R9: A message whose `msg_bank` is not below NUM_BANKS changes no register. Reads of such a bank, and reads of `reg_addr[1:0]`=3, return 0.
- R10: `msg_ready` is always 1, and every valid cycle is accepted.
- R11: Pending bits in different banks all drive the single `irq`. It stays high until the last pending bit in any bank is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message strobe |
| msg_ready | output | 1 | Always 1; no back-pressure |
| msg_bank | input | BANK_IDX_W | Target bank of the message |
| msg_vec | input | 5 | Vector number within the bank |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | BANK_IDX_W+2 | {bank, register select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Registered active-high level interrupt |

## Verification
Directed messages cover four cases:
- an enabled vector against a disabled one, which checks that the enable gate really blocks capture;
- an enabled vector against an enabled but masked one, which separates recording a message from signalling it;
- a message in the same cycle as a clearing write to the same bit, which shows whether the set wins;
- a message to a bank index past the configured count, which must touch nothing.

Pending bits spread over two banks show whether the output is a true OR across banks rather than tracking only the most recent one. Long random traffic mixes messages, clears, enable and mask writes against a cycle-accurate model of every register and of `irq`, which exposes timing slips in the registered output.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int VEC_N     = 32;
  localparam int VEC_IDX_W = $clog2(VEC_N);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/msi_agg_bank.sv
module msi_agg_bank
  import msi_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic [VEC_IDX_W-1:0] hit_vec,
  input  logic                 wr,
  input  reg_sel_e             wr_sel,
  input  logic [VEC_N-1:0]     wr_data,
  output logic [VEC_N-1:0]     status_q,
  output logic [VEC_N-1:0]     enable_q,
  output logic [VEC_N-1:0]     mask_q,
  output logic                 pending
);
  logic [VEC_N-1:0] set_vec;
  logic [VEC_N-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    if (hit) set_vec = (VEC_N'(1) << hit_vec) & enable_q;
    clr_vec = (wr && wr_sel == SEL_STATUS) ? wr_data : '0;
  end

  // set is OR-ed after the clear so a same-cycle message survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (wr && wr_sel == SEL_ENABLE) enable_q <= wr_data;
      if (wr && wr_sel == SEL_MASK)   mask_q   <= wr_data;
    end
  end

  assign pending = |(status_q & enable_q & ~mask_q);
endmodule

// File: rtl/msi_agg_fold.sv
module msi_agg_fold #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pend;
  end
endmodule

// File: rtl/msi_agg.sv
module msi_agg
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_IDX_W = 2,
  localparam int ADDR_W    = BANK_IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_valid,
  output logic                  msg_ready,
  input  logic [BANK_IDX_W-1:0] msg_bank,
  input  logic [VEC_IDX_W-1:0]  msg_vec,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq
);
  logic [VEC_N-1:0]     st_q [NUM_BANKS];
  logic [VEC_N-1:0]     en_q [NUM_BANKS];
  logic [VEC_N-1:0]     mk_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend;

  logic [BANK_IDX_W-1:0] addr_bank;
  reg_sel_e              addr_sel;

  assign addr_bank = reg_addr[ADDR_W-1:2];
  assign addr_sel  = reg_sel_e'(reg_addr[1:0]);
  assign msg_ready = 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_b;
    logic wr_b;
    assign hit_b = msg_valid && (msg_bank == BANK_IDX_W'(b));
    assign wr_b  = reg_we && (addr_bank == BANK_IDX_W'(b));

    msi_agg_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_b),
      .hit_vec  (msg_vec),
      .wr       (wr_b),
      .wr_sel   (addr_sel),
      .wr_data  (reg_wdata),
      .status_q (st_q[b]),
      .enable_q (en_q[b]),
      .mask_q   (mk_q[b]),
      .pending  (pend[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_bank == BANK_IDX_W'(b)) begin
        case (addr_sel)
          SEL_STATUS: reg_rdata = st_q[b];
          SEL_ENABLE: reg_rdata = en_q[b];
          SEL_MASK:   reg_rdata = mk_q[b];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end

  msi_agg_fold #(.N(NUM_BANKS)) u_fold (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .irq   (irq)
  );
endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_IDX_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    msg_valid,
  input logic                    msg_ready,
  input logic [BANK_IDX_W-1:0]   msg_bank,
  input logic [4:0]              msg_vec,
  input logic                    reg_we,
  input logic [BANK_IDX_W+1:0]   reg_addr,
  input logic [31:0]             reg_wdata,
  input logic                    irq,
  input logic [31:0]             st_q [NUM_BANKS],
  input logic [31:0]             en_q [NUM_BANKS],
  input logic [31:0]             mk_q [NUM_BANKS]
);
  logic                        in_rng, tgt_en, tgt_mk, tgt_st, clr_same, any_pend;
  logic                        post_bit;
  logic [NUM_BANKS*32-1:0]     st_flat;
  logic [BANK_IDX_W-1:0]       bank_q;
  logic [4:0]                  vec_q;

  always_comb begin
    in_rng   = 32'(msg_bank) < NUM_BANKS;
    tgt_en   = 1'b0;
    tgt_mk   = 1'b0;
    tgt_st   = 1'b0;
    post_bit = 1'b0;
    any_pend = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      st_flat[b*32 +: 32] = st_q[b];
      any_pend = any_pend | (|(st_q[b] & en_q[b] & ~mk_q[b]));
      if (msg_bank == BANK_IDX_W'(b)) begin
        tgt_en = en_q[b][msg_vec];
        tgt_mk = mk_q[b][msg_vec];
        tgt_st = st_q[b][msg_vec];
      end
      if (bank_q == BANK_IDX_W'(b)) post_bit = st_q[b][vec_q];
    end
    clr_same = reg_we && (reg_addr[BANK_IDX_W+1:2] == msg_bank) &&
               (reg_addr[1:0] == 2'd0) && reg_wdata[msg_vec];
  end

  always_ff @(posedge clk) begin
    bank_q <= msg_bank;
    vec_q  <= msg_vec;
  end

  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready);

  a_r3_disabled_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && in_rng && !tgt_en && !clr_same |=> post_bit == $past(tgt_st));

  a_r5_masked_latches: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && in_rng && tgt_en && tgt_mk |=> post_bit);

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && in_rng && tgt_en && clr_same |=> post_bit);

  a_r4_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq);

  a_r4_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq);

  a_r9_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !in_rng && !reg_we |=> $stable(st_flat));
endmodule

bind msi_agg msi_agg_chk #(.NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)) u_chk (.*);

// File: tb/msi_agg_tb.sv
module msi_agg_tb;
  localparam int NB = 3;
  localparam int BW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [BW-1:0] msg_bank = '0;
  logic [4:0]  msg_vec = '0;
  logic        reg_we = 1'b0;
  logic [BW+1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msi_agg #(.NUM_BANKS(NB), .BANK_IDX_W(BW)) u_dut (.*);

  // reference model
  logic [31:0] m_st [4];
  logic [31:0] m_en [4];
  logic [31:0] m_mk [4];
  bit exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin m_st[b] = '0; m_en[b] = '0; m_mk[b] = '0; end
      exp_q.delete();
    end else begin
      bit p;
      int wb;
      p = 1'b0;
      for (int b = 0; b < NB; b++) p = p | (|(m_st[b] & m_en[b] & ~m_mk[b]));
      exp_q.push_back(p);
      wb = int'(reg_addr[BW+1:2]);
      if (reg_we && wb < NB) begin
        if (reg_addr[1:0] == 2'd0) m_st[wb] = m_st[wb] & ~reg_wdata;
      end
      if (msg_valid && int'(msg_bank) < NB)
        m_st[msg_bank] = m_st[msg_bank] | ((32'd1 << msg_vec) & m_en[msg_bank]);
      if (reg_we && wb < NB) begin
        if (reg_addr[1:0] == 2'd1) m_en[wb] = reg_wdata;
        if (reg_addr[1:0] == 2'd2) m_mk[wb] = reg_wdata;
      end
    end
  end

  // monitor: pops expected irq for every active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      checks++;
      if (irq !== e) begin
        errors++;
        $display("FAIL R4 irq level: actual %0b expected %0b at %0t", irq, e, $time);
      end
    end
  end

  function automatic logic [31:0] model_read(logic [BW+1:0] a);
    int b;
    b = int'(a[BW+1:2]);
    if (b >= NB) return '0;
    case (a[1:0])
      2'd0: return m_st[b];
      2'd1: return m_en[b];
      2'd2: return m_mk[b];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives address, samples combinational read
  task automatic rd(input string tag, input int b, input int sel, input logic [31:0] exp);
    reg_addr = {BW'(b), 2'(sel)};
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " model"}, model_read(reg_addr), exp);
  endtask

  task automatic cyc(input bit mv, input int mb, input int vec,
                     input bit we, input int wb, input int sel, input logic [31:0] wd);
    msg_valid = mv; msg_bank = BW'(mb); msg_vec = 5'(vec);
    reg_we = we; reg_addr = {BW'(wb), 2'(sel)}; reg_wdata = wd;
    @(negedge clk);
    msg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 3; s++) rd("R1 reset reg", b, s, 32'd0);
    chk("R10 ready", {31'd0, msg_ready}, 32'd1);

    // R3 disabled vector
    cyc(1, 0, 4, 0, 0, 0, 0);
    rd("R3 disabled no latch", 0, 0, 32'd0);

    // R2 enabled vector latches, R4 raises irq
    cyc(0, 0, 0, 1, 0, 1, 32'h0000_00F0);
    cyc(1, 0, 4, 0, 0, 0, 0);
    rd("R2 status set", 0, 0, 32'h10);
    idle(1);
    chk("R4 irq high", {31'd0, irq}, 32'd1);

    // R6 write-one-to-clear, zeros leave bits
    cyc(1, 0, 5, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 32'h10);
    rd("R6 partial clear", 0, 0, 32'h20);
    cyc(0, 0, 0, 1, 0, 0, 32'h20);
    idle(1);
    chk("R4 irq falls", {31'd0, irq}, 32'd0);

    // R5 masked vector latches but no irq
    cyc(0, 0, 0, 1, 1, 2, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF);
    cyc(1, 1, 31, 0, 0, 0, 0);
    idle(2);
    rd("R5 masked status", 1, 0, 32'h8000_0000);
    chk("R5 masked no irq", {31'd0, irq}, 32'd0);

    // R8 unmask asserts irq one edge after mask change
    cyc(0, 0, 0, 1, 1, 2, 32'h0);
    chk("R8 irq not yet", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R8 irq after unmask", {31'd0, irq}, 32'd1);

    // R7 set beats clear in same cycle
    cyc(1, 1, 31, 1, 1, 0, 32'h8000_0000);
    rd("R7 set wins", 1, 0, 32'h8000_0000);

    // R11 two banks fold into one line
    cyc(0, 0, 0, 1, 2, 1, 32'h1);
    cyc(1, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 32'hFFFF_FFFF);
    idle(1);
    chk("R11 irq held by bank2", {31'd0, irq}, 32'd1);
    cyc(0, 0, 0, 1, 2, 0, 32'h1);
    idle(1);
    chk("R11 irq drops after last", {31'd0, irq}, 32'd0);

    // R9 out-of-range bank ignored
    cyc(0, 0, 0, 1, 0, 1, 32'hFFFF_FFFF);
    cyc(1, 3, 7, 0, 0, 0, 0);
    rd("R9 bank0 untouched", 0, 0, 32'h0);
    rd("R9 bank1 untouched", 1, 0, 32'h0);
    rd("R9 bank2 untouched", 2, 0, 32'h0);
    rd("R9 oob read", 3, 0, 32'h0);
    rd("R9 sel3 read", 0, 3, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 3), $urandom_range(0, 31),
          r < 4, $urandom_range(0, 3), r < 2 ? 0 : $urandom_range(0, 3),
          $urandom_range(0, 3) == 0 ? 32'hFFFF_FFFF : $urandom());
    end
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 3; s++) rd("R2 R6 random regs", b, s, model_read({BW'(b), 2'(s)}));

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule